// File: doc/BRIEF.md
# Programmable Integer Clock Divider

The block divides its input clock by a programmable integer. A ratio code `n` selects division by `n+1`. A phase code delays the divided output by a set number of input cycles. It produces two outputs from one position counter: a one-cycle enable at the start of every output period, and a divided clock level. A companion status bit reports whether the duty-cycle stabilizer is active. Only the enable logic of the stabilizer is modelled, not the stabilizer itself. Any division other than by one forces the stabilizer on.

Ratio and phase are taken only at a resynchronization point. That point is the first cycle after reset, or the last input cycle of an output period. A new setting therefore never cuts a period short. The output holds low for the effective phase before the first period under a setting. It does this after reset, and whenever a newly loaded ratio or effective phase differs from the active one. Reloading an unchanged setting keeps the periods back to back.

Top module: `clkdiv_top`

## Requirements
- R1: With active ratio code n, the output period is n+1 input cycles, and `div_ce_o` is high only in the first cycle of each period.
- R2: For ratio codes other than 0, `div_clk_o` is high for the first floor((n+1)/2) cycles of each period and low for the rest. Even divisions therefore give half duty.
- R3: With ratio code 0, `div_ce_o` and `div_clk_o` are high in every cycle once running.
- R4: After reset, or after loading a ratio or effective phase that differs from the active one, both outputs stay low for exactly the effective phase in cycles before the first period starts. Reloading an unchanged setting adds no delay.
- R5: The effective phase is the phase code modulo n+1, so a code equal to or above n+1 wraps.
- R6: `ratio_i` and `phase_i` are sampled only at the clock edge that ends the first cycle after reset or the last cycle of a period. A change at any other time has no effect on the period in progress.
- R7: `dcs_active_o` is high when the active ratio code is non-zero. Otherwise it equals `dcs_en_i` as registered on the previous clock edge.
- R8: The registered stabilizer enable resets to 1, so `dcs_active_o` is high in the first cycle after reset whatever `dcs_en_i` is.
- R9: In the first cycle after reset, `div_ce_o` and `div_clk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | RATIO_W (3) | Ratio code n, divide by n+1 |
| phase_i | input | PHASE_W (3) | Phase delay code in input cycles |
| dcs_en_i | input | 1 | Stabilizer enable request |
| div_ce_o | output | 1 | One-cycle enable at each period start |
| div_clk_o | output | 1 | Divided clock level |
| dcs_active_o | output | 1 | Stabilizer active status |

## Verification
The bench builds the block with the default three-bit ratio and phase codes. This gives every division from 1 to 8. Every phase code at or above the ratio wraps, for all divisions except by eight. Random setting changes fall both at period ends and in mid-period, so wrap, delay insertion and the ignored mid-period updates all occur. A second reset with division by one and the enable low exercises the reset value of the enable and its later release.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } div_state_e;
endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg #(
  parameter int RATIO_W = 3,
  parameter int PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [RATIO_W-1:0] ratio_q_o,
  output logic [RATIO_W-1:0] phase_q_o,
  output logic [RATIO_W-1:0] phase_nxt_o,
  output logic               chg_o
);
  localparam int MOD_W = (RATIO_W + 1 > PHASE_W) ? RATIO_W + 1 : PHASE_W;

  logic [MOD_W-1:0] len_w;
  logic [MOD_W-1:0] ph_w;

  assign len_w       = MOD_W'(ratio_i) + MOD_W'(1);
  assign ph_w        = MOD_W'(phase_i);
  // effective phase always below the division length
  assign phase_nxt_o = RATIO_W'(ph_w % len_w);
  assign chg_o       = (ratio_i != ratio_q_o) || (phase_nxt_o != phase_q_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q_o <= '0;
      phase_q_o <= '0;
    end else if (load_i) begin
      ratio_q_o <= ratio_i;
      phase_q_o <= phase_nxt_o;
    end
  end

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(ratio_q_o) && $stable(phase_q_o)));
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_q_i,
  input  logic [RATIO_W-1:0] phase_q_i,
  input  logic [RATIO_W-1:0] phase_nxt_i,
  input  logic               chg_i,
  output logic               load_o,
  output logic               ce_o,
  output logic               clk_o
);
  div_state_e         state_q;
  logic [RATIO_W-1:0] pos_q;
  logic [RATIO_W-1:0] dly_q;
  logic [RATIO_W:0]   half_w;

  assign half_w = ({1'b0, ratio_q_i} + 1'b1) >> 1;
  assign load_o = (state_q == ST_LOAD) || ((state_q == ST_RUN) && (pos_q == ratio_q_i));
  assign ce_o   = (state_q == ST_RUN) && (pos_q == '0);
  assign clk_o  = (state_q == ST_RUN) && ((ratio_q_i == '0) || ({1'b0, pos_q} < half_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      pos_q   <= '0;
      dly_q   <= '0;
    end else begin
      unique case (state_q)
        ST_DELAY: begin
          if (dly_q == '0) begin
            state_q <= ST_RUN;
            pos_q   <= '0;
          end else begin
            dly_q <= dly_q - 1'b1;
          end
        end
        default: begin
          if (load_o) begin
            // delay only on a fresh start or a changed setting
            if (((state_q == ST_LOAD) || chg_i) && (phase_nxt_i != '0)) begin
              state_q <= ST_DELAY;
              dly_q   <= phase_nxt_i - 1'b1;
            end else begin
              state_q <= ST_RUN;
              pos_q   <= '0;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
      endcase
    end
  end

  p_ce_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o && (ratio_q_i != '0)) |=> !ce_o);
  p_ce_in_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> clk_o);
  p_div1_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN) && (ratio_q_i == '0)) |-> (ce_o && clk_o));
  p_delay_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY) |-> (dly_q < phase_q_i));
endmodule

// File: rtl/clkdiv_dcs.sv
module clkdiv_dcs #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_q_i,
  output logic               active_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_i;
  end

  assign active_o = en_q || (ratio_q_i != '0);

  p_dcs_forced_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q_i != '0) |-> active_o);
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
  parameter int RATIO_W = 3,
  parameter int PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               dcs_en_i,
  output logic               div_ce_o,
  output logic               div_clk_o,
  output logic               dcs_active_o
);
  logic               load_w;
  logic               chg_w;
  logic [RATIO_W-1:0] ratio_q_w;
  logic [RATIO_W-1:0] phase_q_w;
  logic [RATIO_W-1:0] phase_nxt_w;

  clkdiv_cfg #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_w),
    .ratio_i     (ratio_i),
    .phase_i     (phase_i),
    .ratio_q_o   (ratio_q_w),
    .phase_q_o   (phase_q_w),
    .phase_nxt_o (phase_nxt_w),
    .chg_o       (chg_w)
  );

  clkdiv_seq #(.RATIO_W(RATIO_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_q_i   (ratio_q_w),
    .phase_q_i   (phase_q_w),
    .phase_nxt_i (phase_nxt_w),
    .chg_i       (chg_w),
    .load_o      (load_w),
    .ce_o        (div_ce_o),
    .clk_o       (div_clk_o)
  );

  clkdiv_dcs #(.RATIO_W(RATIO_W)) u_dcs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (dcs_en_i),
    .ratio_q_i (ratio_q_w),
    .active_o  (dcs_active_o)
  );
endmodule

// File: tb/clkdiv_top_tb_top.sv
module clkdiv_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RATIO_W    = 3;
  localparam int PHASE_W    = 3;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [RATIO_W-1:0] ratio_i = '0;
  logic [PHASE_W-1:0] phase_i = '0;
  logic               dcs_en_i = 1'b0;
  logic               div_ce_o, div_clk_o, dcs_active_o;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  // entry: {delay, wrapped, ratio code[2:0], ce, clk}
  logic [6:0] exp_q[$];
  bit         first_cfg;
  bit         mid_chg;
  int         act_n, act_p;

  clkdiv_top #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ratio_i      (ratio_i),
    .phase_i      (phase_i),
    .dcs_en_i     (dcs_en_i),
    .div_ce_o     (div_ce_o),
    .div_clk_o    (div_clk_o),
    .dcs_active_o (dcs_active_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic act, input logic expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic fill(input int nc, input int ph);
    int  len = nc + 1;
    int  pe  = ph % len;
    bit  wr  = (ph >= len);
    bit  chg = first_cfg || (nc != act_n) || (pe != act_p);
    if (chg)
      for (int i = 0; i < pe; i++) exp_q.push_back({1'b1, wr, 3'(nc), 1'b0, 1'b0});
    for (int i = 0; i < len; i++) begin
      logic c = (len == 1) ? 1'b1 : (i < len / 2);
      exp_q.push_back({1'b0, wr, 3'(nc), (i == 0), c});
    end
    act_n = nc; act_p = pe; first_cfg = 0; mid_chg = 0;
  endtask

  task automatic check_cycle();
    logic [6:0] e;
    if (exp_q.size() == 0) begin
      chk("R1 model underrun", 1'b1, 1'b0);
      return;
    end
    e = exp_q.pop_front();
    if (e[6]) begin
      chk("R4 delay ce", div_ce_o, 1'b0);
      chk("R4 delay clk", div_clk_o, 1'b0);
    end else if (e[4:2] == 3'd0) begin
      chk("R3 div1 ce", div_ce_o, 1'b1);
      chk("R3 div1 clk", div_clk_o, 1'b1);
    end else begin
      chk(e[5] ? "R5 wrapped ce" : (mid_chg ? "R6 mid-period ce" : "R1 ce"), div_ce_o, e[1]);
      chk("R2 clk level", div_clk_o, e[0]);
    end
    chk("R7 status", dcs_active_o, dcs_en_i | (e[4:2] != 3'd0));
  endtask

  task automatic release_reset();
    rst_ni = 1'b1;
    #1;
    chk("R9 ce after reset", div_ce_o, 1'b0);
    chk("R9 clk after reset", div_clk_o, 1'b0);
    chk("R8 status after reset", dcs_active_o, 1'b1);
    exp_q.delete();
    first_cfg = 1;
    fill(int'(ratio_i), int'(phase_i));
  endtask

  task automatic run(input int cycles, input bit rnd);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i);
      check_cycle();
      if (rnd) begin
        if ($urandom % 24 == 0) begin
          ratio_i = RATIO_W'($urandom);
          phase_i = PHASE_W'($urandom);
          if (exp_q.size() != 0) mid_chg = 1;
        end
        if ($urandom % 16 == 0) dcs_en_i = ~dcs_en_i;
      end
      if (exp_q.size() == 0) fill(int'(ratio_i), int'(phase_i));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1D));
    // directed: divide by 6 with phase code 6 (wraps to 0)
    ratio_i = 3'd5; phase_i = 3'd6; dcs_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    release_reset();
    run(40, 0);
    // directed: divide by 4 with phase 3, then divide by 3 with phase 7
    ratio_i = 3'd3; phase_i = 3'd3;
    run(30, 0);
    ratio_i = 3'd2; phase_i = 3'd7;
    run(30, 0);
    run(4000, 1);
    // second reset: divide by 1, enable low
    @(negedge clk_i);
    rst_ni = 1'b0;
    ratio_i = 3'd0; phase_i = 3'd3; dcs_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    release_reset();
    run(20, 0);
    dcs_en_i = 1'b1;
    run(10, 0);
    run(2000, 1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule